// File: doc/BRIEF.md
# Scoreboard Issue and Completion Controller

This block schedules a small floating-point pipeline with a scoreboard. Instructions arrive in program order through a valid/ready handshake. Each one carries an operation class, a destination register and two source registers. The controller issues each instruction in order to a free function unit of the right class. It then moves the instruction through operand read, execution and result write, and lets instructions complete out of program order. Execution is modelled only as a countdown of the unit's latency. No operand values exist in the block.

Two tables hold the state. A per-unit status table records the busy state, destination, sources, producer tags and ready flags of each unit. A per-register table records which unit will write each register next. The block separates the two kinds of data hazard and resolves them in opposite directions. A consumer that needs a value not yet produced waits in operand read until the producer has written. A producer whose destination is still needed by an older reader waits in result write until that reader has fetched its operands. Issue refuses a second pending writer to the same register, and this is what keeps the two kinds of wait free of deadlock.

For each unit, every cycle, the block reports when an instruction completes operand read, execution or result write. It also reports the unit an instruction is issued to and whether issue is stalled. A bench can rebuild a per-instruction timing trace from these outputs.

Top module: `sb_sched_top`

## Requirements
- R1: Each instruction completes issue, operand read, execution end and result write in four strictly increasing cycles. Operand read is no earlier than the cycle after issue. Result write is no earlier than the cycle after execution ends. Every stage other than execution lasts one cycle.
- R2: Execution ends exactly MUL_LAT cycles (default 3) after the operand-read cycle for a multiply, and ADD_LAT cycles (default 1) after it for an add or subtract.
- R3: Operation code in_op is 0 for add, 1 for subtract, and 2 or 3 for multiply, so bit 1 selects the multiply class. Units 0 to NMUL-1 are multiply units and the remaining units are add units. An instruction is issued only to an idle unit of its class, and that unit is the lowest-numbered idle one.
- R4 (RAW): An instruction reads its operands in cycle max(its issue cycle, the result-write cycle of the latest earlier instruction that writes either source) + 1. It never reads earlier and never later.
- R5 (WAR): An instruction writes its result only after every earlier instruction that reads its destination register has completed operand read. The write comes at least one cycle after that read.
- R6 (WAW): An instruction is not issued while an earlier instruction with the same destination has not written its result. Its issue cycle is later than that write.
- R7: Issue is in program order. in_ready is high exactly when an idle unit of the requested class exists and the destination has no pending writer. issue_stall equals in_valid with in_ready low.
- R8: At most one result write happens per cycle. Among instructions eligible to write, the oldest wins. An eligible instruction never waits through a cycle in which no write takes place.
- R9: After reset all units are idle: in_ready is high and no stage-completion event or stall is reported.
- R10: Completion may differ from program order. In a multiply, dependent subtract, independent add sequence whose add overwrites the subtract's second source, the add writes before the subtract.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An instruction is presented |
| in_op | input | 2 | Operation code (0 add, 1 subtract, 2/3 multiply) |
| in_dst | input | REG_W | Destination register index |
| in_src1 | input | REG_W | First source register index |
| in_src2 | input | REG_W | Second source register index |
| in_ready | output | 1 | The presented instruction is issued at this edge if valid |
| issue_stall | output | 1 | A presented instruction cannot issue this cycle |
| iss_unit | output | FU_W | Unit that receives the presented instruction |
| rd_done | output | NFU | Per unit: operand read completes this cycle |
| ex_done | output | NFU | Per unit: execution ends this cycle |
| wr_done | output | NFU | Per unit: result write completes this cycle |

## Verification
The hardest situation to reach is a chain in which a write is held back by an older reader while that reader is itself held back by an even older producer. On top of this, a write-slot collision has to be resolved by age. Uniform register choice rarely builds such a chain. The stimulus therefore opens with the three-instruction multiply, subtract, add sequence and checks its exact cycle trace. It then draws a long random stream whose registers come from only six indices, with occasional idle gaps. This keeps raw, war and waw overlaps and same-cycle write contention frequent. Every instruction's four stage cycles are then compared with bench-computed rules.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_EX   = 2'd2,
    ST_WR   = 2'd3
  } st_e;

  typedef logic [7:0] age_t;

  // Bit 1 of the operation code selects the multiply class.
  function automatic logic op_is_mul(input logic [1:0] op);
    return op[1];
  endfunction

  // Execute countdown loaded when operands are read.
  function automatic logic [7:0] exec_lat(input logic mul, input int ml, input int al);
    return mul ? 8'(ml) : 8'(al);
  endfunction

  // Wrap-safe age comparison: a issued before b.
  function automatic logic age_older(input age_t a, input age_t b);
    logic signed [7:0] d;
    d = a - b;
    return d < 0;
  endfunction

endpackage

// File: rtl/sb_issue_sel.sv
module sb_issue_sel #(
  parameter int NMUL = 2,
  parameter int NADD = 2,
  localparam int NFU  = NMUL + NADD,
  localparam int FU_W = (NFU > 1) ? $clog2(NFU) : 1
) (
  input  logic [NFU-1:0]  free,
  input  logic            want_mul,
  output logic            found,
  output logic [FU_W-1:0] unit
);
  always_comb begin
    found = 1'b0;
    unit  = '0;
    for (int u = 0; u < NFU; u++) begin
      if (!found && free[u] && ((u < NMUL) == want_mul)) begin
        found = 1'b1;
        unit  = FU_W'(u);
      end
    end
  end
endmodule

// File: rtl/sb_wr_arb.sv
module sb_wr_arb import sb_pkg::*; #(
  parameter int NFU = 4,
  localparam int FU_W = (NFU > 1) ? $clog2(NFU) : 1
) (
  input  logic [NFU-1:0]      elig,
  input  logic [NFU-1:0][7:0] age,
  output logic [NFU-1:0]      grant,
  output logic                any,
  output logic [FU_W-1:0]     idx
);
  always_comb begin
    any   = 1'b0;
    idx   = '0;
    grant = '0;
    for (int u = 0; u < NFU; u++) begin
      if (elig[u] && (!any || age_older(age[u], age[idx]))) begin
        any = 1'b1;
        idx = FU_W'(u);
      end
    end
    if (any) grant[idx] = 1'b1;
  end
endmodule

// File: rtl/sb_reg_status.sv
module sb_reg_status #(
  parameter int NREG = 16,
  parameter int FU_W = 2,
  localparam int REG_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       set_en,
  input  logic [REG_W-1:0]           set_reg,
  input  logic [FU_W-1:0]            set_fu,
  input  logic                       clr_en,
  input  logic [REG_W-1:0]           clr_reg,
  output logic [NREG-1:0]            pend,
  output logic [NREG-1:0][FU_W-1:0]  owner
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[r]  <= 1'b0;
        owner[r] <= '0;
      end else if (set_en && set_reg == REG_W'(r)) begin
        pend[r]  <= 1'b1;
        owner[r] <= set_fu;
      end else if (clr_en && clr_reg == REG_W'(r)) begin
        pend[r]  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sb_sched_top.sv
module sb_sched_top import sb_pkg::*; #(
  parameter int NMUL    = 2,
  parameter int NADD    = 2,
  parameter int NREG    = 16,
  parameter int MUL_LAT = 3,
  parameter int ADD_LAT = 1,
  localparam int NFU   = NMUL + NADD,
  localparam int FU_W  = (NFU > 1) ? $clog2(NFU) : 1,
  localparam int REG_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_op,
  input  logic [REG_W-1:0] in_dst,
  input  logic [REG_W-1:0] in_src1,
  input  logic [REG_W-1:0] in_src2,
  output logic             in_ready,
  output logic             issue_stall,
  output logic [FU_W-1:0]  iss_unit,
  output logic [NFU-1:0]   rd_done,
  output logic [NFU-1:0]   ex_done,
  output logic [NFU-1:0]   wr_done
);
  // Unit status table
  st_e                  st  [NFU];
  logic [REG_W-1:0]     fi  [NFU];
  logic [REG_W-1:0]     fj  [NFU];
  logic [REG_W-1:0]     fk  [NFU];
  logic [FU_W-1:0]      qj  [NFU];
  logic [FU_W-1:0]      qk  [NFU];
  logic [7:0]           cnt [NFU];
  logic [NFU-1:0]       rj, rk, fmul;
  logic [NFU-1:0][7:0]  age;
  age_t                 age_ctr;

  // Named internal events
  logic                 sel_found, waw_hit, issue_fire;
  logic [FU_W-1:0]      sel_unit;
  logic [NFU-1:0]       free, war_blk, elig;
  logic                 wr_any;
  logic [FU_W-1:0]      wr_idx;
  logic [REG_W-1:0]     wr_reg;
  logic                 src1_rdy, src2_rdy;
  logic [NREG-1:0]      pend;
  logic [NREG-1:0][FU_W-1:0] owner;

  always_comb begin
    for (int u = 0; u < NFU; u++) begin
      free[u]    = (st[u] == ST_IDLE);
      rd_done[u] = (st[u] == ST_RD) && rj[u] && rk[u];
      ex_done[u] = (st[u] == ST_EX) && (cnt[u] == 8'd1);
    end
  end

  sb_issue_sel #(.NMUL(NMUL), .NADD(NADD)) u_sel (
    .free(free), .want_mul(op_is_mul(in_op)), .found(sel_found), .unit(sel_unit)
  );

  assign waw_hit     = pend[in_dst];
  assign in_ready    = sel_found && !waw_hit;
  assign issue_fire  = in_valid && in_ready;
  assign issue_stall = in_valid && !in_ready;
  assign iss_unit    = sel_unit;

  // WAR: a writer is held while any unit still waiting to read holds a
  // ready flag on a source that names the writer's destination.
  always_comb begin
    war_blk = '0;
    for (int u = 0; u < NFU; u++) begin
      for (int f = 0; f < NFU; f++) begin
        if (f != u && st[f] == ST_RD &&
            ((rj[f] && fj[f] == fi[u]) || (rk[f] && fk[f] == fi[u])))
          war_blk[u] = 1'b1;
      end
      elig[u] = (st[u] == ST_WR) && !war_blk[u];
    end
  end

  sb_wr_arb #(.NFU(NFU)) u_arb (
    .elig(elig), .age(age), .grant(wr_done), .any(wr_any), .idx(wr_idx)
  );

  assign wr_reg = fi[wr_idx];

  sb_reg_status #(.NREG(NREG), .FU_W(FU_W)) u_rstat (
    .clk(clk), .rst_n(rst_n),
    .set_en(issue_fire), .set_reg(in_dst), .set_fu(sel_unit),
    .clr_en(wr_any), .clr_reg(wr_reg),
    .pend(pend), .owner(owner)
  );

  // A source is ready at issue if no writer is pending or it writes now.
  assign src1_rdy = !pend[in_src1] || (wr_any && owner[in_src1] == wr_idx);
  assign src2_rdy = !pend[in_src2] || (wr_any && owner[in_src2] == wr_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_ctr <= '0;
      rj      <= '0;
      rk      <= '0;
      fmul    <= '0;
      age     <= '0;
      for (int u = 0; u < NFU; u++) begin
        st[u]  <= ST_IDLE;
        fi[u]  <= '0;
        fj[u]  <= '0;
        fk[u]  <= '0;
        qj[u]  <= '0;
        qk[u]  <= '0;
        cnt[u] <= '0;
      end
    end else begin
      if (issue_fire) age_ctr <= age_ctr + 8'd1;
      for (int u = 0; u < NFU; u++) begin
        if (issue_fire && sel_unit == FU_W'(u)) begin
          st[u]   <= ST_RD;
          fi[u]   <= in_dst;
          fj[u]   <= in_src1;
          fk[u]   <= in_src2;
          qj[u]   <= owner[in_src1];
          qk[u]   <= owner[in_src2];
          rj[u]   <= src1_rdy;
          rk[u]   <= src2_rdy;
          fmul[u] <= op_is_mul(in_op);
          age[u]  <= age_ctr;
        end else begin
          case (st[u])
            ST_RD: begin
              if (rd_done[u]) begin
                st[u]  <= ST_EX;
                cnt[u] <= exec_lat(fmul[u], MUL_LAT, ADD_LAT);
                rj[u]  <= 1'b0;
                rk[u]  <= 1'b0;
              end else begin
                if (wr_any && !rj[u] && qj[u] == wr_idx) rj[u] <= 1'b1;
                if (wr_any && !rk[u] && qk[u] == wr_idx) rk[u] <= 1'b1;
              end
            end
            ST_EX: begin
              cnt[u] <= cnt[u] - 8'd1;
              if (cnt[u] == 8'd1) st[u] <= ST_WR;
            end
            ST_WR: begin
              if (wr_done[u]) st[u] <= ST_IDLE;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/sb_sched_chk.sv
module sb_sched_chk #(
  parameter int NMUL    = 2,
  parameter int NADD    = 2,
  parameter int MUL_LAT = 3,
  parameter int ADD_LAT = 1,
  localparam int NFU  = NMUL + NADD,
  localparam int FU_W = (NFU > 1) ? $clog2(NFU) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [1:0]      in_op,
  input logic [FU_W-1:0] iss_unit,
  input logic [NFU-1:0]  rd_done,
  input logic [NFU-1:0]  ex_done,
  input logic [NFU-1:0]  wr_done
);
  logic fire;
  assign fire = in_valid && in_ready;

  logic [NFU-1:0] busy_c, await_rd, ex_seen;
  logic [7:0]     since [NFU];

  for (genvar u = 0; u < NFU; u++) begin : g_u
    localparam int LU = (u < NMUL) ? MUL_LAT : ADD_LAT;
    logic hit;
    assign hit = fire && iss_unit == FU_W'(u);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy_c[u]   <= 1'b0;
        await_rd[u] <= 1'b0;
        ex_seen[u]  <= 1'b0;
        since[u]    <= '0;
      end else begin
        if (hit) begin
          busy_c[u]   <= 1'b1;
          await_rd[u] <= 1'b1;
        end else begin
          if (wr_done[u]) busy_c[u] <= 1'b0;
          if (rd_done[u]) await_rd[u] <= 1'b0;
        end
        if (ex_done[u]) ex_seen[u] <= 1'b1;
        else if (wr_done[u]) ex_seen[u] <= 1'b0;
        if (rd_done[u]) since[u] <= 8'd1;
        else if (since[u] != 8'd0 && since[u] != 8'hff) since[u] <= since[u] + 8'd1;
      end
    end

    assert_read_after_issue_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done[u] |-> await_rd[u]);
    assert_write_after_exec_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done[u] |-> ex_seen[u]);
    assert_exec_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ex_done[u] |-> since[u] == 8'(LU));
  end

  assert_issue_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> ((int'(iss_unit) < NMUL) == in_op[1]));
  assert_issue_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !busy_c[iss_unit]);
  assert_one_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_done));
endmodule

bind sb_sched_top sb_sched_chk #(
  .NMUL(NMUL), .NADD(NADD), .MUL_LAT(MUL_LAT), .ADD_LAT(ADD_LAT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .iss_unit(iss_unit), .rd_done(rd_done),
  .ex_done(ex_done), .wr_done(wr_done)
);

// File: tb/sb_sched_top_tb.sv
`timescale 1ns/1ps
module sb_sched_top_tb;
  localparam int NMUL = 2, NADD = 2, NFU = 4, NREG = 16;
  localparam int MLAT = 3, ALAT = 1;
  localparam int N = 300, MAXC = 20000, CB = 8192;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [1:0] in_op = '0;
  logic [3:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic in_ready, issue_stall;
  logic [1:0] iss_unit;
  logic [NFU-1:0] rd_done, ex_done, wr_done;

  always #2.5 clk = ~clk;

  sb_sched_top u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
    .in_ready(in_ready), .issue_stall(issue_stall), .iss_unit(iss_unit),
    .rd_done(rd_done), .ex_done(ex_done), .wr_done(wr_done)
  );

  int checks = 0, fails = 0;
  int r_op[N], r_dst[N], r_s1[N], r_s2[N];
  int r_unit[N], r_iss[N], r_rd[N], r_ex[N], r_wr[N];
  int wr_who[CB];
  int owner[NFU];
  int pend[NREG];
  int cyc = 0, nxt = 0, nwr = 0;
  bit run = 0, need_load = 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int lat_of(input int op);
    return (op >= 2) ? MLAT : ALAT;
  endfunction

  function automatic int first_free(input int op);
    for (int u = 0; u < NFU; u++)
      if (owner[u] < 0 && ((u < NMUL) == (op >= 2))) return u;
    return -1;
  endfunction

  // Monitor and driver: drive at the falling edge, sample 1 ns later.
  always @(negedge clk) begin
    if (run) begin
      cyc++;
      if (need_load && nxt < N) begin
        if (nxt < 3 || ($urandom % 6) != 0) begin
          in_op = 2'(r_op[nxt]); in_dst = 4'(r_dst[nxt]);
          in_src1 = 4'(r_s1[nxt]); in_src2 = 4'(r_s2[nxt]);
          in_valid = 1'b1; need_load = 0;
        end else in_valid = 1'b0;
      end else if (nxt >= N) in_valid = 1'b0;
      #1;
      chk($countones(wr_done) <= 1, "R8 one write per cycle", $countones(wr_done), 1);
      for (int u = 0; u < NFU; u++) begin
        if (rd_done[u]) begin
          chk(owner[u] >= 0, "R1 read on idle unit", u, -1);
          if (owner[u] >= 0) r_rd[owner[u]] = cyc;
        end
        if (ex_done[u] && owner[u] >= 0) r_ex[owner[u]] = cyc;
        if (wr_done[u] && owner[u] >= 0) begin
          r_wr[owner[u]] = cyc;
          if (cyc < CB) wr_who[cyc] = owner[u];
          nwr++;
        end
      end
      if (in_valid) begin
        automatic int fu = first_free(r_op[nxt]);
        automatic bit exp_rdy = (fu >= 0) && (pend[r_dst[nxt]] < 0);
        chk(in_ready == exp_rdy, "R7 in_ready", in_ready, exp_rdy);
        chk(issue_stall == !exp_rdy, "R7 issue_stall", issue_stall, !exp_rdy);
        if (in_valid && in_ready) begin
          chk(int'(iss_unit) == fu, "R3 lowest idle unit of class", iss_unit, fu);
          r_iss[nxt] = cyc; r_unit[nxt] = iss_unit;
          owner[iss_unit] = nxt; pend[r_dst[nxt]] = nxt;
          nxt++; need_load = 1;
        end
      end
      for (int u = 0; u < NFU; u++) begin
        if (wr_done[u] && owner[u] >= 0 && r_wr[owner[u]] == cyc) begin
          if (pend[r_dst[owner[u]]] == owner[u]) pend[r_dst[owner[u]]] = -1;
          owner[u] = -1;
        end
      end
    end
  end

  initial begin
    void'($urandom(32'd1729));
    // Directed opening: mul r0=r2*r4, sub r8=r0-r14, add r14=r2+r6
    r_op[0] = 2; r_dst[0] = 0;  r_s1[0] = 2; r_s2[0] = 4;
    r_op[1] = 1; r_dst[1] = 8;  r_s1[1] = 0; r_s2[1] = 14;
    r_op[2] = 0; r_dst[2] = 14; r_s1[2] = 2; r_s2[2] = 6;
    for (int i = 3; i < N; i++) begin
      r_op[i] = int'($urandom % 4); r_dst[i] = int'($urandom % 6);
      r_s1[i] = int'($urandom % 6); r_s2[i] = int'($urandom % 6);
    end
    for (int i = 0; i < N; i++) begin
      r_iss[i] = -1; r_rd[i] = -1; r_ex[i] = -1; r_wr[i] = -1; r_unit[i] = -1;
    end
    for (int c = 0; c < CB; c++) wr_who[c] = -1;
    for (int u = 0; u < NFU; u++) owner[u] = -1;
    for (int r = 0; r < NREG; r++) pend[r] = -1;

    repeat (3) @(negedge clk);
    #1;
    chk(in_ready == 1'b1, "R9 ready in reset", in_ready, 1);
    chk((rd_done | ex_done | wr_done) == '0, "R9 no events in reset", rd_done | ex_done | wr_done, 0);
    chk(issue_stall == 1'b0, "R9 no stall in reset", issue_stall, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R9 ready after reset", in_ready, 1);
    run = 1;
    while (!(nxt >= N && nwr >= N) && cyc < MAXC) @(negedge clk);
    run = 0;
    if (cyc >= MAXC) chk(1'b0, "R1 watchdog expired", nwr, N);

    // Directed exact trace
    chk(r_iss[0] == 1 && r_rd[0] == 2 && r_ex[0] == 5 && r_wr[0] == 6, "R2 mul trace", r_wr[0], 6);
    chk(r_iss[1] == 2 && r_rd[1] == 7, "R4 sub waits raw", r_rd[1], 7);
    chk(r_ex[1] == 8 && r_wr[1] == 9, "R1 sub completion", r_wr[1], 9);
    chk(r_iss[2] == 3 && r_rd[2] == 4 && r_ex[2] == 5, "R2 add trace", r_ex[2], 5);
    chk(r_wr[2] == 8, "R5 add waits war", r_wr[2], 8);
    chk(r_wr[2] < r_wr[1], "R10 add completes before sub", r_wr[2], r_wr[1]);

    // Per-instruction rules
    for (int i = 0; i < N; i++) begin
      automatic int exp_rd, elig, prev_dst;
      automatic bit bad;
      if (r_wr[i] < 0) begin
        chk(1'b0, "R1 instruction never completed", i, -1);
        continue;
      end
      chk(r_iss[i] < r_rd[i] && r_rd[i] < r_ex[i] && r_ex[i] < r_wr[i], "R1 stage order", r_rd[i], r_iss[i] + 1);
      chk(r_ex[i] - r_rd[i] == lat_of(r_op[i]), "R2 latency", r_ex[i] - r_rd[i], lat_of(r_op[i]));
      chk((r_unit[i] < NMUL) == (r_op[i] >= 2), "R3 unit class", r_unit[i], r_op[i]);
      if (i > 0) chk(r_iss[i] > r_iss[i-1], "R7 in-order issue", r_iss[i], r_iss[i-1] + 1);
      exp_rd = r_iss[i];
      prev_dst = -1;
      for (int j = 0; j < i; j++) begin
        if (r_dst[j] == r_s1[i] || r_dst[j] == r_s2[i]) begin
          for (int k = j + 1; k < i; k++) ;
        end
      end
      for (int s = 0; s < 2; s++) begin
        automatic int src = (s == 0) ? r_s1[i] : r_s2[i];
        for (int j = i - 1; j >= 0; j--)
          if (r_dst[j] == src) begin
            if (r_wr[j] > exp_rd) exp_rd = r_wr[j];
            break;
          end
      end
      exp_rd++;
      chk(r_rd[i] == exp_rd, "R4 raw read cycle", r_rd[i], exp_rd);
      for (int j = i - 1; j >= 0; j--)
        if (r_dst[j] == r_dst[i]) begin prev_dst = j; break; end
      if (prev_dst >= 0) chk(r_iss[i] > r_wr[prev_dst], "R6 waw issue", r_iss[i], r_wr[prev_dst] + 1);
      elig = r_ex[i] + 1;
      for (int j = 0; j < i; j++)
        if ((r_s1[j] == r_dst[i] || r_s2[j] == r_dst[i]) && r_rd[j] + 1 > elig) elig = r_rd[j] + 1;
      chk(r_wr[i] >= elig, "R5 war write after reads", r_wr[i], elig);
      bad = 0;
      for (int c = elig; c < r_wr[i] && c < CB; c++)
        if (wr_who[c] < 0 || wr_who[c] > i) bad = 1;
      chk(!bad, "R8 oldest eligible writes without idle slot", r_wr[i], elig);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule